// File: doc/BRIEF.md
# Interleaved Parity Checker with Remote Error Indication

The block watches a received byte stream and checks it against a parity byte that the sender places in the stream. For each frame it folds every byte flagged as covered into an even bit-interleaved parity word (one parity bit per bit lane). When the next frame arrives, that word is held and compared with the parity byte of the new frame, which the upstream framer marks with a strobe. The number of bit lanes that differ is the error count for that frame.

Each error count is added to a saturating counter. The counter is read through a simple register port and is cleared by the read. A count that arrives in the same cycle as the read goes into the cleared counter and is not lost. The per-frame error count is also sent out on a 4-bit remote error indication output. A transmit framer places this value in the upper nibble (bits 7:4) of its outgoing path status byte. An enable input forces that output to zero when insertion is turned off.

A small tracking state machine decides when a comparison is valid. Its states are:

- `TRK_SEEK`: no frame start has been seen yet.
- `TRK_OPEN`: the first frame is being accumulated, and no reference exists yet.
- `TRK_ARMED`: a reference is held and is waiting for its parity byte.
- `TRK_DONE`: the reference has been used in this frame.

Its transitions are:

- SEEK→OPEN on the first frame start.
- OPEN/ARMED/DONE→ARMED on a frame start with no parity strobe.
- OPEN/ARMED/DONE→DONE on a frame start that coincides with a parity strobe.
- ARMED→DONE on a parity strobe.

Top module: `bip8_rei_chk`

## Requirements
- R1: After reset the counter reads 0, `rei_value` is 0 and `rei_valid` is 0. No comparison happens until a second frame start has closed a complete frame.
- R2: The reference parity is even and bit-interleaved. Bit i is the XOR of bit i of every byte presented with `byte_covered`=1 between two frame starts, including the frame-start byte itself when that byte is covered. Uncovered bytes have no effect.
- R3: The reference of frame N is compared with the byte strobed by `parity_strobe` in frame N+1. A parity strobe in the very first frame after reset is ignored.
- R4: The error count of a comparison is the number of differing bit positions, from 0 to 8. It is added to the counter.
- R5: Only the first parity strobe of a frame is compared. Later strobes in the same frame change neither the counter nor the REI output.
- R6: If `parity_strobe` and `frame_start` are asserted in the same cycle, that byte is compared with the frame that just closed.
- R7: If a frame ends without a parity strobe, its held reference is discarded without counting, and the newly closed frame becomes the reference.
- R8: The counter saturates at 2^CNT_W-1 and stays there until it is read.
- R9: `cnt_rdata` shows the counter value. In a cycle with `cnt_rd`=1, the counter is cleared, and the counter then holds exactly the error count of any comparison made in that same cycle.
- R10: One cycle after a comparison, `rei_valid` is 1 for one cycle. `rei_value` carries that comparison's error count (binary, bit 0 = LSB) and holds it until the next comparison.
- R11: While `rei_enable`=0, `rei_value` reads 0. When `rei_enable` returns to 1, the output shows the last stored count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | LANES | Received byte |
| frame_start | input | 1 | First byte of a frame |
| byte_covered | input | 1 | Byte counts into parity |
| parity_strobe | input | 1 | Byte is the parity byte for the previous frame |
| cnt_rd | input | 1 | Read strobe; clears the counter |
| cnt_rdata | output | CNT_W | Error counter value |
| rei_enable | input | 1 | REI insertion enable |
| rei_value | output | REI_W | Error count for the status byte bits 7:4 |
| rei_valid | output | 1 | New REI value this cycle |

## Verification
The bench aims at the cycles where the trackers can disagree:
- **Parity strobe in the very first frame.** A design that compared it would count garbage from reset.
- **Parity strobe on a frame-start cycle.** A wrong design would compare against the stale reference or fold the byte into the new frame.
- **Second strobe in one frame.** Counting it would double-count errors.
- **Frame with no strobe.** A wrong design would keep an outdated reference.
- **Read that lands on a comparison.** A wrong design would drop the count.
- **Saturation.** A wrong design would wrap the counter to a small value.

A behavioural model is also compared on every cycle under random traffic.

// File: rtl/bip8_pkg.sv
package bip8_pkg;

    typedef enum logic [1:0] {
        TRK_SEEK  = 2'd0,
        TRK_OPEN  = 2'd1,
        TRK_ARMED = 2'd2,
        TRK_DONE  = 2'd3
    } trk_state_t;

endpackage

// File: rtl/bip8_track_fsm.sv
module bip8_track_fsm
    import bip8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic parity_strobe,
    output logic cmp_go
);

    trk_state_t state_q;
    trk_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_SEEK;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_SEEK: begin
                if (frame_start) state_d = TRK_OPEN;
            end
            TRK_OPEN: begin
                if (frame_start) state_d = parity_strobe ? TRK_DONE : TRK_ARMED;
            end
            TRK_ARMED: begin
                if (frame_start)        state_d = parity_strobe ? TRK_DONE : TRK_ARMED;
                else if (parity_strobe) state_d = TRK_DONE;
            end
            TRK_DONE: begin
                if (frame_start) state_d = parity_strobe ? TRK_DONE : TRK_ARMED;
            end
            default: state_d = TRK_SEEK;
        endcase
    end

    always_comb begin
        cmp_go = 1'b0;
        unique case (state_q)
            TRK_SEEK:  cmp_go = 1'b0;
            TRK_OPEN:  cmp_go = frame_start && parity_strobe;
            TRK_ARMED: cmp_go = parity_strobe;
            TRK_DONE:  cmp_go = frame_start && parity_strobe;
            default:   cmp_go = 1'b0;
        endcase
    end

    // R5
    done_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_DONE && !frame_start) |-> !cmp_go);

    // R3
    cmp_marks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_go |=> (state_q == TRK_DONE));

    // R1
    seek_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_SEEK) |-> !cmp_go);

endmodule

// File: rtl/bip8_par_unit.sv
module bip8_par_unit #(
    parameter int LANES = 8,
    localparam int ERR_W = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] rx_byte,
    input  logic             frame_start,
    input  logic             byte_covered,
    output logic [ERR_W-1:0] err_bits
);

    logic [LANES-1:0] acc_q;
    logic [LANES-1:0] ref_q;
    logic [LANES-1:0] ref_sel;
    logic [LANES-1:0] diff;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ref_q <= '0;
        end else begin
            if (frame_start) begin
                ref_q <= acc_q;
                acc_q <= byte_covered ? rx_byte : '0;
            end else if (byte_covered) begin
                acc_q <= acc_q ^ rx_byte;
            end
        end
    end

    // A strobe on a frame-start byte belongs to the frame just closed.
    assign ref_sel = frame_start ? acc_q : ref_q;
    assign diff    = ref_sel ^ rx_byte;

    always_comb begin
        err_bits = '0;
        for (int i = 0; i < LANES; i++) begin
            err_bits = err_bits + ERR_W'(diff[i]);
        end
    end

    // R2
    uncovered_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !byte_covered) |=> $stable(acc_q));

    // R2
    ref_only_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(ref_q));

endmodule

// File: rtl/bip8_err_cnt.sv
module bip8_err_cnt #(
    parameter int CNT_W = 16,
    parameter int ERR_W = 4,
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_vld,
    input  logic [ERR_W-1:0] err_bits,
    input  logic             cnt_rd,
    output logic [CNT_W-1:0] cnt_rdata
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;

    always_comb begin
        base = cnt_rd ? '0 : cnt_q;
        sum  = {1'b0, base} + (err_vld ? (CNT_W + 1)'(err_bits) : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        end
    end

    assign cnt_rdata = cnt_q;

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !cnt_rd) |=> (cnt_q == CNT_MAX));

    // R4
    no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_rd |=> (cnt_q >= $past(cnt_q)));

    // R4
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_rd |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(LANES)));

    // R9
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd && !err_vld) |=> (cnt_q == '0));

endmodule

// File: rtl/bip8_rei_out.sv
module bip8_rei_out #(
    parameter int ERR_W = 4,
    parameter int REI_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_vld,
    input  logic [ERR_W-1:0] err_bits,
    input  logic             rei_enable,
    output logic [REI_W-1:0] rei_value,
    output logic             rei_valid
);

    logic [REI_W-1:0] rei_q;
    logic             vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rei_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= err_vld;
            if (err_vld) rei_q <= REI_W'(err_bits);
        end
    end

    assign rei_value = rei_enable ? rei_q : '0;
    assign rei_valid = vld_q;

    // R10
    rei_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_vld |=> $stable(rei_q));

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rei_valid |-> $past(err_vld));

endmodule

// File: rtl/bip8_rei_chk.sv
module bip8_rei_chk #(
    parameter int LANES = 8,
    parameter int CNT_W = 16,
    parameter int REI_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] rx_byte,
    input  logic             frame_start,
    input  logic             byte_covered,
    input  logic             parity_strobe,
    input  logic             cnt_rd,
    output logic [CNT_W-1:0] cnt_rdata,
    input  logic             rei_enable,
    output logic [REI_W-1:0] rei_value,
    output logic             rei_valid
);

    localparam int ERR_W = $clog2(LANES + 1);

    logic             cmp_go;
    logic [ERR_W-1:0] err_bits;

    bip8_track_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start   (frame_start),
        .parity_strobe (parity_strobe),
        .cmp_go        (cmp_go)
    );

    bip8_par_unit #(.LANES(LANES)) u_par (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_byte      (rx_byte),
        .frame_start  (frame_start),
        .byte_covered (byte_covered),
        .err_bits     (err_bits)
    );

    bip8_err_cnt #(.CNT_W(CNT_W), .ERR_W(ERR_W), .LANES(LANES)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_vld   (cmp_go),
        .err_bits  (err_bits),
        .cnt_rd    (cnt_rd),
        .cnt_rdata (cnt_rdata)
    );

    bip8_rei_out #(.ERR_W(ERR_W), .REI_W(REI_W)) u_rei (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_vld    (cmp_go),
        .err_bits   (err_bits),
        .rei_enable (rei_enable),
        .rei_value  (rei_value),
        .rei_valid  (rei_valid)
    );

    // R11
    rei_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rei_valid |-> (rei_value <= REI_W'(LANES)));

endmodule

// File: tb/bip8_rei_chk_bench.sv
module bip8_rei_chk_bench;

    localparam int CNT_W = 10;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       rx_byte = '0;
    logic             frame_start = 1'b0;
    logic             byte_covered = 1'b0;
    logic             parity_strobe = 1'b0;
    logic             cnt_rd = 1'b0;
    logic             rei_enable = 1'b0;
    logic [CNT_W-1:0] cnt_rdata;
    logic [3:0]       rei_value;
    logic             rei_valid;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    // behavioural model
    int m_frames = 0;
    bit m_pending = 0;
    int m_acc = 0;
    int m_ref = 0;
    int m_cnt = 0;
    int m_rei = 0;
    bit m_vld = 0;

    always #5 clk = ~clk;

    bip8_rei_chk #(.LANES(8), .CNT_W(CNT_W), .REI_W(4)) u_bip8_rei_chk (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_byte       (rx_byte),
        .frame_start   (frame_start),
        .byte_covered  (byte_covered),
        .parity_strobe (parity_strobe),
        .cnt_rd        (cnt_rd),
        .cnt_rdata     (cnt_rdata),
        .rei_enable    (rei_enable),
        .rei_value     (rei_value),
        .rei_valid     (rei_valid)
    );

    function automatic int bits_set(int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        bit cmp = 0;
        int refv = 0;
        int err = 0;
        int b = int'(rx_byte);
        if (frame_start && m_frames >= 1 && parity_strobe) begin
            cmp = 1; refv = m_acc;
        end else if (!frame_start && m_pending && parity_strobe) begin
            cmp = 1; refv = m_ref;
        end
        if (cmp) err = bits_set(refv ^ b);
        m_cnt = cnt_rd ? 0 : m_cnt;
        if (cmp) m_cnt += err;
        if (m_cnt > CMAX) m_cnt = CMAX;
        m_vld = cmp;
        if (cmp) m_rei = err;
        if (frame_start) begin
            if (m_frames >= 1) begin
                m_ref = m_acc;
                m_pending = !parity_strobe;
            end else begin
                m_pending = 0;
            end
            if (m_frames < 2) m_frames++;
            m_acc = byte_covered ? b : 0;
        end else begin
            if (cmp) m_pending = 0;
            if (byte_covered) m_acc = m_acc ^ b;
        end
    endtask

    task automatic compare_all();
        chk(tag, int'(cnt_rdata), m_cnt, "counter");
        chk(tag, int'(rei_value), rei_enable ? m_rei : 0, "rei_value");
        chk(tag, int'(rei_valid), int'(m_vld), "rei_valid");
    endtask

    task automatic cyc(bit fs, bit cov, bit ps, logic [7:0] b, bit rd);
        frame_start = fs; byte_covered = cov; parity_strobe = ps;
        rx_byte = b; cnt_rd = rd;
        @(posedge clk);
        model_step();
        @(negedge clk);
        frame_start = 0; byte_covered = 0; parity_strobe = 0; cnt_rd = 0;
        compare_all();
    endtask

    initial begin
        #(150000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset values
        chk("R1", int'(cnt_rdata), 0, "counter in reset");
        chk("R1", int'(rei_valid), 0, "rei_valid in reset");
        rst_n = 1'b1;
        rei_enable = 1'b1;
        @(negedge clk);
        chk("R1", int'(rei_value), 0, "rei_value after reset");

        // R3 strobe in first frame ignored
        tag = "R3";
        cyc(1, 1, 0, 8'h11, 0);
        cyc(0, 0, 1, 8'h00, 0);
        chk("R3", int'(rei_valid), 0, "first-frame strobe");
        cyc(0, 1, 0, 8'h22, 0);

        // R2 uncovered byte excluded, R4 count of differing bits
        tag = "R4";
        cyc(1, 1, 0, 8'hA5, 0);
        cyc(0, 0, 0, 8'hFF, 0);
        cyc(0, 1, 0, 8'h3C, 0);
        cyc(0, 0, 1, 8'h30, 0);      // ref 0x33 vs 0x30 -> 2
        chk("R4", int'(cnt_rdata), 2, "two-bit error count");
        chk("R10", int'(rei_value), 2, "rei carries count");
        chk("R10", int'(rei_valid), 1, "rei_valid pulse");

        // R5 second strobe ignored
        tag = "R5";
        cyc(0, 0, 1, 8'h00, 0);
        chk("R5", int'(cnt_rdata), 2, "second strobe");
        chk("R5", int'(rei_value), 2, "rei after second strobe");

        // R6 strobe on frame start vs closed frame (0x99), R2 parity
        tag = "R6";
        cyc(1, 0, 1, 8'h98, 0);
        chk("R6", int'(cnt_rdata), 3, "coincident strobe");
        chk("R2", int'(rei_value), 1, "parity excludes uncovered");
        cyc(0, 1, 0, 8'h0F, 0);

        // R7 frame without strobe discards old reference
        tag = "R7";
        cyc(1, 1, 0, 8'hF0, 0);
        cyc(0, 1, 0, 8'h01, 0);
        cyc(1, 0, 0, 8'h00, 0);
        cyc(0, 0, 1, 8'hF1, 0);      // ref 0xF1 -> 0 errors
        chk("R7", int'(cnt_rdata), 3, "stale reference dropped");
        chk("R7", int'(rei_value), 0, "zero-error compare");

        // R9 read with same-cycle compare
        tag = "R9";
        chk("R9", int'(cnt_rdata), 3, "read value");
        cyc(1, 0, 1, 8'h07, 1);      // ref 0 vs 0x07 -> 3
        chk("R9", int'(cnt_rdata), 3, "count kept across clear");
        cyc(0, 0, 0, 8'h00, 1);
        chk("R9", int'(cnt_rdata), 0, "clear by read");

        // R11 enable gating
        tag = "R11";
        rei_enable = 1'b0;
        #1;
        chk("R11", int'(rei_value), 0, "disabled output");
        rei_enable = 1'b1;
        #1;
        chk("R11", int'(rei_value), 3, "re-enabled output");

        // R8 saturation
        tag = "R8";
        for (int k = 0; k < 200; k++) cyc(1, 0, 1, 8'hFF, 0);
        chk("R8", int'(cnt_rdata), CMAX, "saturated");
        cyc(0, 0, 0, 8'h00, 1);
        chk("R8", int'(cnt_rdata), 0, "read after saturation");

        // R4 random traffic against the model
        tag = "R4";
        for (int k = 0; k < 3000; k++) begin
            rei_enable = ($urandom_range(0, 7) != 0);
            cyc(($urandom_range(0, 9) == 0), $urandom_range(0, 1),
                ($urandom_range(0, 5) == 0), 8'($urandom),
                ($urandom_range(0, 30) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule